// File: doc/BRIEF.md
# Noise-Shaped Fractional Clock Divider

This block derives a slower clock from a fast parent clock by dividing it by a value made of an integer part I and a 12-bit fraction F, so the divisor is I + F/4096. Each output period is a whole number of parent cycles. A cascade of up to three accumulator stages picks the length of each period so that the long-run average period equals the fractional divisor. The selected shaping order decides how far a single period may stray from I. A low order keeps periods tight for loads that need a steady waveform. A high order pushes the error to higher frequencies, at the cost of a wider spread.

The divisor and order are sampled only while `en` is low. When `en` is raised, periods follow one another with no gap. When `en` is lowered, the period already in progress completes and the output then stays low. A divisor that would let the chosen order produce a period shorter than two parent cycles raises `cfg_err`, and while that flag is set the output produces no edges.

Top module: `frac_clk_div`

## Requirements
- R1: While reset is held, and afterwards until enabled, `clk_out` is low and `cfg_err` is low for a legal divisor.
- R2: With `mash_ord` = 0 (integer only), every period lasts exactly I parent cycles.
- R3: With `mash_ord` = 1 (first order), every period lasts I or I+1 parent cycles.
- R4: With `mash_ord` = 2 (second order), every period lies in I-1 .. I+2 parent cycles. For example, I=3, F=512 gives periods from 2 to 5.
- R5: With `mash_ord` = 3 (third order), every period lies in I-3 .. I+4 parent cycles.
- R6: Over N consecutive periods, the total number of parent cycles equals N*I + N*F/4096 within 4 cycles.
- R7: `cfg_err` is high when I < 5 in order 3, when I < 3 in order 2, and when I < 2 in orders 0 and 1. While it is high, no period starts and `clk_out` stays low.
- R8: Changes to `div_int`, `div_frac` and `mash_ord` made while `en` is high do not alter the running sequence.
- R9: When `en` falls, the current period completes, no further rising edge follows, and `clk_out` stays low.
- R10: In each period of P cycles, `clk_out` is high for the first floor(P/2) cycles and low for the rest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; the configuration is sampled while low |
| div_int | input | INT_W | Integer part I of the divisor |
| div_frac | input | FRAC_W | Fraction F of the divisor, in units of 1/2^FRAC_W |
| mash_ord | input | 2 | Shaping order: 0 integer, 1 first, 2 second, 3 third |
| clk_out | output | 1 | Divided clock |
| cfg_err | output | 1 | Sampled divisor is illegal for the sampled order |

## Verification
The critical coincidence is the end of a period landing in the same cycle as a change at the block's edge. One case is the divisor or order inputs moving while the block runs. The bench changes them mid-sequence and checks that the following periods keep the old range and the old long-run average. The other case is `en` falling while a period is in progress. The bench lowers it in the cycle right after a rising edge, then checks that the high phase still runs its full length and that no new edge appears.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

   typedef enum logic [1:0] {
      ORD_INT    = 2'd0,
      ORD_FIRST  = 2'd1,
      ORD_SECOND = 2'd2,
      ORD_THIRD  = 2'd3
   } shaper_ord_e;

   localparam int MIN_PERIOD = 2;
   localparam int STAGES     = 3;

   // how far below I the shortest period of an order can fall
   function automatic int below_int(shaper_ord_e o);
      case (o)
         ORD_SECOND: return 1;
         ORD_THIRD:  return 3;
         default:    return 0;
      endcase
   endfunction

endpackage

// File: rtl/fdiv_acc_stage.sv
module fdiv_acc_stage #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         adv,
   input  logic [W-1:0] addend,
   output logic [W-1:0] sum_nxt,
   output logic         carry_nxt
);
   logic [W-1:0] acc_q;

   assign {carry_nxt, sum_nxt} = {1'b0, acc_q} + {1'b0, addend};

   always_ff @(posedge clk) begin
      if (!rst_n)   acc_q <= '0;
      else if (clr) acc_q <= '0;
      else if (adv) acc_q <= sum_nxt;
   end
endmodule

// File: rtl/fdiv_noise_comb.sv
module fdiv_noise_comb
   import fdiv_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              adv,
   input  logic [STAGES-1:0] carry,
   input  shaper_ord_e       ord,
   output logic signed [3:0] delta
);
   logic c2_p, c3_p, c3_pp;
   logic signed [3:0] t1, t2, t3;

   always_comb begin
      t1 = $signed({3'b000, carry[0]});
      t2 = $signed({3'b000, carry[1]}) - $signed({3'b000, c2_p});
      t3 = $signed({3'b000, carry[2]}) - $signed({2'b00, c3_p, 1'b0})
         + $signed({3'b000, c3_pp});
      case (ord)
         ORD_FIRST:  delta = t1;
         ORD_SECOND: delta = t1 + t2;
         ORD_THIRD:  delta = t1 + t2 + t3;
         default:    delta = 4'sd0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         c2_p  <= 1'b0;
         c3_p  <= 1'b0;
         c3_pp <= 1'b0;
      end else if (adv) begin
         c2_p  <= carry[1];
         c3_p  <= carry[2];
         c3_pp <= c3_p;
      end
   end
endmodule

// File: rtl/fdiv_period_gen.sv
module fdiv_period_gen #(
   parameter int PW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [PW-1:0] per_nxt,
   output logic          load,
   output logic          run,
   output logic [PW-1:0] per_q,
   output logic          clk_out
);
   logic [PW-1:0] cnt_q;
   logic          last;

   assign last    = (cnt_q == per_q - 1'b1);
   assign load    = go && (!run || last);
   assign clk_out = run && (cnt_q < (per_q >> 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run   <= 1'b0;
         cnt_q <= '0;
         per_q <= PW'(2);
      end else if (load) begin
         run   <= 1'b1;
         cnt_q <= '0;
         per_q <= per_nxt;
      end else if (run) begin
         if (last) begin
            run   <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
   import fdiv_pkg::*;
#(
   parameter int INT_W  = 8,
   parameter int FRAC_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [INT_W-1:0]  div_int,
   input  logic [FRAC_W-1:0] div_frac,
   input  logic [1:0]        mash_ord,
   output logic              clk_out,
   output logic              cfg_err
);
   localparam int PW = INT_W + 1;

   if (INT_W < 3) begin : g_bad_int
      $error("frac_clk_div: INT_W must be at least 3");
   end
   if (FRAC_W < 2) begin : g_bad_frac
      $error("frac_clk_div: FRAC_W must be at least 2");
   end

   logic [INT_W-1:0]  int_q;
   logic [FRAC_W-1:0] frac_q;
   shaper_ord_e       ord_q, ord_in;
   logic              err_q, err_in;
   logic              run_w, load_w, clr_w;
   logic [PW-1:0]     per_w, per_nxt;
   logic signed [3:0] delta;
   logic signed [PW:0] per_s;

   assign ord_in = shaper_ord_e'(mash_ord);
   assign err_in = ({1'b0, div_int} < PW'(MIN_PERIOD + below_int(ord_in)));

   // configuration shadow: follows the inputs only while disabled
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         int_q  <= INT_W'(MIN_PERIOD);
         frac_q <= '0;
         ord_q  <= ORD_INT;
         err_q  <= 1'b0;
      end else if (!en) begin
         int_q  <= div_int;
         frac_q <= div_frac;
         ord_q  <= ord_in;
         err_q  <= err_in;
      end
   end

   assign clr_w = !en && !run_w;

   logic [STAGES-1:0][FRAC_W-1:0] stg_in, stg_sum;
   logic [STAGES-1:0]             stg_c;

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_head
         assign stg_in[k] = frac_q;
      end else begin : g_chain
         assign stg_in[k] = stg_sum[k-1];
      end
      fdiv_acc_stage #(.W(FRAC_W)) u_acc (
         .clk       (clk),
         .rst_n     (rst_n),
         .clr       (clr_w),
         .adv       (load_w),
         .addend    (stg_in[k]),
         .sum_nxt   (stg_sum[k]),
         .carry_nxt (stg_c[k])
      );
   end

   fdiv_noise_comb u_comb (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_w),
      .adv   (load_w),
      .carry (stg_c),
      .ord   (ord_q),
      .delta (delta)
   );

   assign per_s   = $signed({2'b00, int_q}) + {{(INT_W-2){delta[3]}}, delta};
   assign per_nxt = per_s[PW-1:0];

   fdiv_period_gen #(.PW(PW)) u_per (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (en && !err_q),
      .per_nxt (per_nxt),
      .load    (load_w),
      .run     (run_w),
      .per_q   (per_w),
      .clk_out (clk_out)
   );

   assign cfg_err = err_q;
endmodule

// File: rtl/fdiv_chk.sv
module fdiv_chk #(
   parameter int INT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             clk_out,
   input logic             cfg_err,
   input logic             run,
   input logic             load,
   input logic [INT_W:0]   per_q,
   input logic [INT_W-1:0] int_q,
   input logic [1:0]       ord_q
);
   logic [INT_W+1:0] lo_c, hi_c, i_x;

   assign i_x = {2'b00, int_q};
   always_comb begin
      case (ord_q)
         2'd1:    begin lo_c = i_x;      hi_c = i_x + 2'd1; end
         2'd2:    begin lo_c = i_x - 1;  hi_c = i_x + 2'd2; end
         2'd3:    begin lo_c = i_x - 3;  hi_c = i_x + 3'd4; end
         default: begin lo_c = i_x;      hi_c = i_x;        end
      endcase
   end

   // R9: no output activity while no period is running
   p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !clk_out);

   // R7: an illegal configuration keeps the divider from starting
   p_err_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err && !run) |=> !run);

   // R7: a running period is never shorter than two cycles
   p_min_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (per_q >= 2));

   // R2 R3 R4 R5: a newly loaded period lies in the window of its order
   p_span_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> ({1'b0, per_q} >= $past(lo_c) && {1'b0, per_q} <= $past(hi_c)));

   // R8: sampled configuration is frozen while enabled
   p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> ($stable(int_q) && $stable(ord_q)));
endmodule

bind frac_clk_div fdiv_chk #(.INT_W(INT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .en      (en),
   .clk_out (clk_out),
   .cfg_err (cfg_err),
   .run     (run_w),
   .load    (load_w),
   .per_q   (per_w),
   .int_q   (int_q),
   .ord_q   (ord_q)
);

// File: tb/tb_frac_clk_div.sv
module tb_frac_clk_div;
   localparam int INT_W  = 8;
   localparam int FRAC_W = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              en = 1'b0;
   logic [INT_W-1:0]  div_int = 8'd4;
   logic [FRAC_W-1:0] div_frac = '0;
   logic [1:0]        mash_ord = 2'd0;
   logic              clk_out, cfg_err;

   always #2 clk = ~clk;

   frac_clk_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) dut (
      .clk(clk), .rst_n(rst_n), .en(en), .div_int(div_int),
      .div_frac(div_frac), .mash_ord(mash_ord),
      .clk_out(clk_out), .cfg_err(cfg_err)
   );

   typedef struct {
      int    i;
      int    f;
      int    lo;
      int    hi;
      int    n;
      string tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   fails  = 0;
   bit   done   = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   // monitor: measures periods and compares against the queued expectation
   initial begin
      forever begin
         exp_t   e;
         logic   p;
         longint sum;
         int     mn, mx, bad_duty, bad_p, bad_h;
         while (q.size() == 0) @(negedge clk);
         e = q[0];
         p = clk_out;
         @(negedge clk);
         while (!(clk_out && !p)) begin p = clk_out; @(negedge clk); end
         sum = 0; mn = 1 << 20; mx = 0; bad_duty = 0; bad_p = 0; bad_h = 0;
         for (int k = 0; k < e.n; k++) begin
            int cyc, hi;
            cyc = 1; hi = 1; p = 1'b1;
            @(negedge clk);
            while (!(clk_out && !p)) begin
               cyc++;
               if (clk_out) hi++;
               p = clk_out;
               @(negedge clk);
            end
            sum += cyc;
            if (cyc < mn) mn = cyc;
            if (cyc > mx) mx = cyc;
            if (hi != cyc / 2 && bad_duty == 0) begin
               bad_duty = 1; bad_p = cyc; bad_h = hi;
            end
         end
         check(mn >= e.lo, e.tag, "shortest period", mn, e.lo);
         check(mx <= e.hi, e.tag, "longest period", mx, e.hi);
         check(bad_duty == 0, "R10", "high cycles in period", bad_h, bad_p / 2);
         begin
            longint target, diff;
            target = longint'(e.n) * e.i + (longint'(e.n) * e.f) / 4096;
            diff = sum - target;
            check(diff <= 4 && diff >= -4, "R6", "total cycles", sum, target);
         end
         void'(q.pop_front());
      end
   end

   task automatic setup(input int i, input int f, input int o);
      en = 1'b0;
      repeat (40) @(negedge clk);
      div_int = INT_W'(i); div_frac = FRAC_W'(f); mash_ord = 2'(o);
      repeat (3) @(negedge clk);
   endtask

   task automatic run_cfg(input int i, input int f, input int o,
                          input int lo, input int hi, input int n, input string tag);
      exp_t e;
      setup(i, f, o);
      e.i = i; e.f = f; e.lo = lo; e.hi = hi; e.n = n; e.tag = tag;
      q.push_back(e);
      en = 1'b1;
      while (q.size() != 0) @(negedge clk);
      en = 1'b0;
   endtask

   task automatic err_case(input int i, input int o, input bit exp_err);
      setup(i, 0, o);
      check(cfg_err == exp_err, "R7", $sformatf("cfg_err I=%0d ord=%0d", i, o),
            cfg_err, exp_err);
   endtask

   initial begin
      repeat (40000 * 5) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      finish_run();
   end

   initial begin
      repeat (5) @(negedge clk);
      check(clk_out == 1'b0, "R1", "clk_out in reset", clk_out, 0);
      check(cfg_err == 1'b0, "R1", "cfg_err in reset", cfg_err, 0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      check(clk_out == 1'b0, "R1", "clk_out idle after reset", clk_out, 0);
      check(cfg_err == 1'b0, "R1", "cfg_err idle after reset", cfg_err, 0);

      run_cfg(5, 0,      0, 5, 5,  64,   "R2");
      run_cfg(6, 12'h5A3, 1, 6, 7,  4096, "R3");
      run_cfg(3, 12'h200, 2, 2, 5,  4096, "R4");
      run_cfg(7, 12'h3A1, 3, 4, 11, 4096, "R5");
      run_cfg(5, 12'hFFF, 3, 2, 9,  512,  "R5");

      // R8: inputs move while running; old range and average must persist
      begin
         exp_t e;
         setup(6, 12'h800, 1);
         e.i = 6; e.f = 12'h800; e.lo = 6; e.hi = 7; e.n = 256; e.tag = "R8";
         q.push_back(e);
         en = 1'b1;
         repeat (300) @(negedge clk);
         div_int = 8'd20; mash_ord = 2'd0; div_frac = '0;
         while (q.size() != 0) @(negedge clk);
         en = 1'b0;
      end

      // R9: drop enable right after a rising edge
      begin
         logic p;
         int   hi, rises;
         setup(8, 0, 0);
         en = 1'b1;
         p = clk_out;
         @(negedge clk);
         while (!(clk_out && !p)) begin p = clk_out; @(negedge clk); end
         en = 1'b0;
         hi = 1; rises = 0; p = 1'b1;
         for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (clk_out && !p) rises++;
            if (clk_out) hi++;
            p = clk_out;
         end
         check(hi == 4, "R9", "high phase completes after disable", hi, 4);
         check(rises == 0, "R9", "rising edges after disable", rises, 0);
         check(clk_out == 1'b0, "R9", "clk_out held low", clk_out, 0);
      end

      // R7: legality boundaries per order
      err_case(4, 3, 1'b1);
      begin
         int highs;
         highs = 0;
         en = 1'b1;
         for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (clk_out) highs++;
         end
         check(highs == 0, "R7", "output cycles high while in error", highs, 0);
         en = 1'b0;
      end
      err_case(5, 3, 1'b0);
      err_case(2, 2, 1'b1);
      err_case(3, 2, 1'b0);
      err_case(1, 0, 1'b1);
      err_case(2, 0, 1'b0);
      err_case(1, 1, 1'b1);
      err_case(2, 1, 1'b0);

      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule